// File: doc/BRIEF.md
# Phase-Domain Digital Phase Detector

This block produces the per-reference-cycle phase error of an all-digital PLL that works in the phase domain. All of its logic runs on the oscillator clock. A reference strobe arrives already retimed into that domain, so both phase quantities are sampled on the same edge. On each accepted strobe, three things happen. A reference phase register adds the frequency control word. A free-running counter of oscillator edges is sampled. A snapshot of 24 latched delay-line taps is decoded into a sub-period delay and a period estimate.

The delay is normalised to a fraction of one oscillator period. The period used for this is the sum of the last 16 period estimates, so the delay is scaled by 16 before the divide. A restoring divider then forms the 16-bit fraction over 16 cycles. The phase error is the reference phase minus the sampled edge count plus that fraction, in unsigned-integer-plus-16-bit-fraction fixed point. It wraps at the counter width and is presented as a signed value with a one-cycle valid pulse.

Top module: `pdpd_phase_detector`

## Requirements
- R1: While `rst` is high, and after it until the first result, `phase_err` is 0 and `err_valid` is 0. The reference phase and the edge count both restart from 0. The period divisor starts at PERIOD_INIT×16, which is 192 by default.
- R2: Each accepted strobe adds `fcw` to the reference phase, modulo 2^24. `fcw` has 8 integer bits above 16 fraction bits.
- R3: The edge counter goes up by one on every clock edge while `rst` is low. It wraps at 8 bits. An accepted strobe samples the count held just before that edge.
- R4: The delay `d` is the lowest index j in 1..23 with `tap_word[j]` different from `tap_word[j-1]`. When there is no such j, `d` is 0.
- R5: A period sample is the distance from that first transition to the next transition of the same kind (the same new bit value). When no such transition exists inside the word, no sample is taken.
- R6: Period samples from accepted strobes are summed in groups of 16. When the 16th sample of a group arrives, the group sum replaces the divisor.
- R7: The fraction is floor(d·16·2^16 / divisor), using the divisor as it stood before the strobe. When d·16 is greater than or equal to the divisor, the fraction saturates at 0xFFFF.
- R8: `phase_err` equals reference phase − (sampled count · 2^16) + fraction, modulo 2^24, read as two's complement.
- R9: `err_valid` is high for exactly one cycle, 18 clock edges after the strobe edge. The edge that first sees the strobe is counted as edge 1. `phase_err` changes only on that edge.
- R10: A strobe arriving within 17 edges after an accepted strobe is ignored. It does not change the reference phase or the period average, and it produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | 1 | Retimed reference strobe, one cycle wide |
| fcw | input | 24 | Frequency control word, 8.16 unsigned |
| tap_word | input | 24 | Latched delay-line taps |
| phase_err | output | 24 | Signed phase error, 8.16 two's complement |
| err_valid | output | 1 | One-cycle pulse marking a new phase error |

## Verification
The bench varies both the position of the first tap transition and the spacing of the transitions. It runs more than 16 strobes, so the divisor is replaced mid-run; a design that averaged over the wrong count, or used the new divisor too early, would give fractions off by a few LSBs. It drives a late transition against a small divisor, where a design without saturation would wrap the fraction. It drives a tap word with no transition, where a design with a mis-indexed search would report a non-zero delay. It sends a strobe during a calculation, where a design that accepted it would double-count the control word and emit an extra result. The run is long enough for the edge counter to wrap, so its contribution to the integer part is also exercised.

// File: rtl/pdpd_pkg.sv
package pdpd_pkg;
  typedef enum logic {
    PD_IDLE = 1'b0,
    PD_CALC = 1'b1
  } pd_state_e;
endpackage

// File: rtl/pdpd_tap_decode.sv
module pdpd_tap_decode #(
  parameter int TAPS = 24,
  localparam int TW = $clog2(TAPS)
) (
  input  logic [TAPS-1:0] taps,
  output logic [TW-1:0]   delay,
  output logic [TW-1:0]   period,
  output logic            period_ok
);
  int  first_pos;
  int  next_pos;
  logic got_first;
  logic got_next;

  always_comb begin
    got_first = 1'b0;
    first_pos = 0;
    for (int j = 1; j < TAPS; j++) begin
      if (!got_first && (taps[j] != taps[j-1])) begin
        got_first = 1'b1;
        first_pos = j;
      end
    end
    got_next = 1'b0;
    next_pos = 0;
    for (int j = 1; j < TAPS; j++) begin
      if (got_first && !got_next && (j > first_pos) &&
          (taps[j] != taps[j-1]) && (taps[j] == taps[first_pos])) begin
        got_next = 1'b1;
        next_pos = j;
      end
    end
    delay     = got_first ? TW'(first_pos) : '0;
    period    = got_next ? TW'(next_pos - first_pos) : '0;
    period_ok = got_next;
  end
endmodule

// File: rtl/pdpd_period_avg.sv
module pdpd_period_avg #(
  parameter int TW          = 5,
  parameter int AVG_LOG2    = 4,
  parameter int PERIOD_INIT = 12,
  localparam int SW = TW + AVG_LOG2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_en,
  input  logic [TW-1:0] sample,
  output logic [SW-1:0] divisor
);
  logic [SW-1:0]       acc;
  logic [AVG_LOG2-1:0] n;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      n       <= '0;
      divisor <= SW'(PERIOD_INIT << AVG_LOG2);
    end else if (sample_en) begin
      if (n == {AVG_LOG2{1'b1}}) begin
        divisor <= acc + SW'(sample);
        acc     <= '0;
      end else begin
        acc <= acc + SW'(sample);
      end
      n <= n + 1'b1;
    end
  end

  AST_DIVISOR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    divisor != '0); // R6
endmodule

// File: rtl/pdpd_frac_div.sv
module pdpd_frac_div #(
  parameter int SW = 9,
  parameter int QW = 16,
  localparam int STW = $clog2(QW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] dividend,
  input  logic [SW-1:0] divisor,
  output logic [QW-1:0] quot,
  output logic          done
);
  logic [SW:0]    rem;
  logic [SW:0]    rem_sh;
  logic [SW-1:0]  dvs;
  logic [QW-1:0]  q;
  logic [STW-1:0] step;
  logic           busy;
  logic           sat;

  always_comb rem_sh = {rem[SW-1:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      dvs  <= '0;
      q    <= '0;
      step <= '0;
      busy <= 1'b0;
      sat  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= {1'b0, dividend};
        dvs  <= divisor;
        sat  <= (dividend >= divisor);
        q    <= '0;
        step <= STW'(QW);
        busy <= 1'b1;
      end else if (busy) begin
        if (rem_sh >= {1'b0, dvs}) begin
          rem <= rem_sh - {1'b0, dvs};
          q   <= {q[QW-2:0], 1'b1};
        end else begin
          rem <= rem_sh;
          q   <= {q[QW-2:0], 1'b0};
        end
        step <= step - 1'b1;
        if (step == STW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = sat ? {QW{1'b1}} : q;
endmodule

// File: rtl/pdpd_phase_detector.sv
module pdpd_phase_detector #(
  parameter int CNT_W       = 8,
  parameter int FRAC_W      = 16,
  parameter int TAPS        = 24,
  parameter int AVG_LOG2    = 4,
  parameter int PERIOD_INIT = 12,
  localparam int PW = CNT_W + FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_stb,
  input  logic [PW-1:0]        fcw,
  input  logic [TAPS-1:0]      tap_word,
  output logic signed [PW-1:0] phase_err,
  output logic                 err_valid
);
  import pdpd_pkg::*;

  localparam int TW = $clog2(TAPS);
  localparam int SW = TW + AVG_LOG2;

  pd_state_e         state;
  logic              accept;
  logic [CNT_W-1:0]  edge_cnt;
  logic [CNT_W-1:0]  cnt_smp;
  logic [PW-1:0]     ref_phase;
  logic [TW-1:0]     delay;
  logic [TW-1:0]     period;
  logic              period_ok;
  logic [SW-1:0]     divisor;
  logic [FRAC_W-1:0] quot;
  logic              div_done;

  assign accept = ref_stb && (state == PD_IDLE);

  pdpd_tap_decode #(.TAPS(TAPS)) u_decode (
    .taps      (tap_word),
    .delay     (delay),
    .period    (period),
    .period_ok (period_ok)
  );

  pdpd_period_avg #(
    .TW(TW), .AVG_LOG2(AVG_LOG2), .PERIOD_INIT(PERIOD_INIT)
  ) u_avg (
    .clk       (clk),
    .rst       (rst),
    .sample_en (accept && period_ok),
    .sample    (period),
    .divisor   (divisor)
  );

  pdpd_frac_div #(.SW(SW), .QW(FRAC_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .dividend ({delay, {AVG_LOG2{1'b0}}}),
    .divisor  (divisor),
    .quot     (quot),
    .done     (div_done)
  );

  always_ff @(posedge clk) begin
    if (rst) edge_cnt <= '0;
    else     edge_cnt <= edge_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PD_IDLE;
      ref_phase <= '0;
      cnt_smp   <= '0;
      phase_err <= '0;
      err_valid <= 1'b0;
    end else begin
      err_valid <= 1'b0;
      if (accept) begin
        state     <= PD_CALC;
        ref_phase <= ref_phase + fcw;
        cnt_smp   <= edge_cnt;
      end
      if (div_done) begin
        phase_err <= $signed(ref_phase - {cnt_smp, {FRAC_W{1'b0}}} + PW'(quot));
        err_valid <= 1'b1;
        state     <= PD_IDLE;
      end
    end
  end

  AST_EDGE_STEP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> edge_cnt == CNT_W'($past(edge_cnt) + 1'b1)); // R3
  AST_IGNORED_STROBE: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(ref_phase)); // R10
  AST_VALID_AFTER_DIV: assert property (@(posedge clk) disable iff (rst)
    div_done |=> err_valid); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> !err_valid); // R9
endmodule

// File: tb/tb_pdpd_phase_detector.sv
module tb_pdpd_phase_detector;
  localparam int PW   = 24;
  localparam int TAPS = 24;
  localparam int LAT  = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_stb = 1'b0;
  logic [PW-1:0] fcw = '0;
  logic [TAPS-1:0] tap_word = '0;
  logic signed [PW-1:0] phase_err;
  logic err_valid;

  typedef struct { logic [PW-1:0] val; int c; } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  int bcnt = 0;
  bit finished = 0;
  logic [PW-1:0] m_ref = '0;
  int m_acc = 0, m_n = 0, m_div = 12 * 16, last_acc = -1000;
  logic [PW-1:0] last_err = '0;

  always #2 clk = ~clk;

  pdpd_phase_detector dut (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .fcw(fcw),
    .tap_word(tap_word), .phase_err(phase_err), .err_valid(err_valid)
  );

  always @(posedge clk) bcnt <= rst ? 0 : bcnt + 1;

  // per == 0 gives an all-ones word with no transition
  task automatic send(input logic [PW-1:0] f, input int first, input int per,
                      input bit pol, input int gap);
    logic [TAPS-1:0] t;
    int d;
    bit pok;
    longint fr;
    exp_t e;
    if (per == 0) begin
      t = '1; d = 0; pok = 0;
    end else begin
      for (int j = 0; j < TAPS; j++) begin
        if (j < first) t[j] = pol;
        else t[j] = (((j - first) % per) < per / 2) ? ~pol : pol;
      end
      d = first;
      pok = (first + per <= TAPS - 1);
    end
    if (bcnt - last_acc >= LAT) begin
      m_ref = m_ref + f;
      if (d * 16 >= m_div) fr = 64'hFFFF;
      else fr = (longint'(d * 16) << 16) / m_div;
      e.val = m_ref - (PW'(bcnt % 256) << 16) + PW'(fr);
      e.c = bcnt;
      sb.push_back(e);
      if (pok) begin
        m_acc += per; m_n++;
        if (m_n == 16) begin m_div = m_acc; m_acc = 0; m_n = 0; end
      end
      last_acc = bcnt;
    end
    ref_stb = 1'b1; fcw = f; tap_word = t;
    @(negedge clk);
    ref_stb = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (err_valid) begin
        exp_t e;
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 unexpected result got %h exp none", phase_err);
        end else begin
          e = sb.pop_front();
          checks++;
          if (phase_err !== e.val) begin
            errors++;
            $display("FAIL R2 R3 R4 R5 R6 R7 R8 phase error got %h exp %h", phase_err, e.val);
          end
          checks++;
          if (bcnt != e.c + LAT) begin
            errors++;
            $display("FAIL R9 latency got %0d exp %0d", bcnt - e.c, LAT);
          end
        end
        last_err = phase_err;
      end else begin
        checks++;
        if (phase_err !== last_err) begin
          errors++;
          $display("FAIL R9 output changed without valid got %h exp %h", phase_err, last_err);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (phase_err !== '0 || err_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state got %h/%b exp 0/0", phase_err, err_valid);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);
    send(24'h0A_8000, 3, 12, 0, 20);
    send(24'h0B_1234, 5, 10, 1, 20);
    send(24'h09_F000, 1, 2, 0, 20);
    for (int i = 0; i < 18; i++)
      send(24'h0A_0000 + PW'(i * 24'h000321), 1 + i % 6, 8 + i % 8, i[0], 20);
    send(24'h0A_0000, 20, 12, 0, 20);   // saturation, R7
    send(24'h0A_4000, 0, 0, 0, 20);     // no transition, R4
    send(24'h0C_0000, 4, 9, 0, 5);
    send(24'h7F_0000, 2, 6, 0, 25);     // ignored, R10
    send(24'h0A_0000, 6, 10, 1, 20);
    repeat (25) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10 pending results got %0d exp 0", sb.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R9 watchdog expired got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule